// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block is the software-visible register file of a two-channel bus-master DMA controller for disk drives. It decodes a 16-byte I/O window split into one 8-byte slice per channel. Each slice holds a command byte, a status byte and a 32-bit pointer to the descriptor table. A separate transfer engine reads the command and pointer values from the block's outputs and reports progress back through per-channel hardware inputs.

The status byte combines three kinds of bit. Some bits are written directly by software. One bit is owned by hardware and cannot be written. Two flags are cleared by writing a one to them. Access to the command/status word is byte-only: a read of any other width returns all ones across its width, and a write of any other width is dropped. Each channel's drive interrupt level is reflected into two outputs, a legacy interrupt line and a sticky configuration flag. Channel 0 feeds legacy line 14 and channel 1 feeds line 15.

Top module: `bmdma_regbank`

## Requirements
- R1: Address bit 3 selects the channel: 0x0-0x7 is channel 0 and 0x8-0xF is channel 1. Within a slice, local offset 0 is the command byte, 2 is the status byte and 4..7 is the descriptor pointer. A write to one channel never changes the other channel's registers.
- R2: On local offsets 0..3, an access with acc_size other than byte (00 byte, 01 halfword, 10 or 11 word) reads all ones for its width, right-justified: 0x0000FFFF for a halfword and 0xFFFFFFFF for a word. A write of that kind changes nothing.
- R3: Byte reads at local offsets 1 and 3 return 0xFF, and byte writes there change nothing.
- R4: A byte write to status stores data bits 6 and 5 into status bits 6 and 5. Status bits 7, 4 and 3 always read zero.
- R5: Status bit 0 (active) equals hw_active of the channel as sampled on the previous clock edge. A software write never changes it.
- R6: Writing 1 to status bit 1 (error) or bit 2 (interrupt) clears that bit. Writing 0 leaves it unchanged.
- R7: A one-cycle pulse on hw_err_set or hw_irq_set sets status bit 1 or bit 2 from the next cycle on. The set wins over a software clear made in the same cycle.
- R8: The pointer takes byte writes (lane addr[1:0]), halfword writes (lane addr[1]) and word writes, with data right-justified on acc_wdata. Reads use the same widths and lanes. Pointer bits 1:0 always read zero.
- R9: A channel's chan_irq level appears on both legacy_irq[n] and cfg_irq_flag[n] one clock later, and it follows both rising and falling edges.
- R10: After reset, all command, status and pointer registers read zero, and legacy_irq and cfg_irq_flag are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte address within the window |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_wdata | input | 32 | Write data, right-justified |
| rd_data | output | 32 | Combinational read data for acc_addr/acc_size |
| hw_active | input | 2 | Per-channel active level from the engine |
| hw_err_set | input | 2 | Per-channel error flag set pulse |
| hw_irq_set | input | 2 | Per-channel interrupt flag set pulse |
| chan_irq | input | 2 | Per-channel drive interrupt level |
| cmd_out | output | 16 | Command bytes, channel n at [8n+7:8n] |
| ptr_out | output | 64 | Descriptor pointers, channel n at [32n+31:32n] |
| legacy_irq | output | 2 | Legacy interrupt lines 14 (bit 0) and 15 (bit 1) |
| cfg_irq_flag | output | 2 | Mirrored interrupt configuration flags |

## Verification
The assertions assume that acc_valid pulses for one cycle per access and that acc_addr and acc_size stay stable while rd_data is sampled. They also assume that the hardware inputs are synchronous to clk. The bench drives every input on the falling edge and holds the hardware set pulses for exactly one cycle. It samples after the next falling edge, so each expected value covers exactly one register stage. In the single case where both sides act in the same cycle, a software clear and a hardware set are made deliberately on the same edge.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int DATA_W   = 32;
    localparam int BYTE_W   = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] sta;
        logic [DATA_W-1:0] ptr;
    } chan_regs_t;

    typedef struct packed {
        logic legacy;
        logic cfg;
    } irq_state_t;
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_sta,
    input  logic [3:0]        ptr_be,
    input  logic [DATA_W-1:0] wdata_rep,
    input  logic              hw_active,
    input  logic              hw_err_set,
    input  logic              hw_irq_set,
    output logic [BYTE_W-1:0] cmd,
    output logic [BYTE_W-1:0] sta,
    output logic [DATA_W-1:0] ptr
);
    chan_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_cmd) begin
            r_d.cmd = wdata_rep[BYTE_W-1:0];
        end
        if (wr_sta) begin
            r_d.sta = {1'b0, wdata_rep[6:5], 2'b00,
                       r_q.sta[2:1] & ~wdata_rep[2:1], r_q.sta[0]};
        end
        r_d.sta[0] = hw_active;
        if (hw_err_set) r_d.sta[1] = 1'b1;
        if (hw_irq_set) r_d.sta[2] = 1'b1;
        for (int b = 0; b < 4; b++) begin
            if (ptr_be[b]) r_d.ptr[b*BYTE_W +: BYTE_W] = wdata_rep[b*BYTE_W +: BYTE_W];
        end
        r_d.ptr[1:0] = 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd = r_q.cmd;
    assign sta = r_q.sta;
    assign ptr = r_q.ptr;

    // R5: active bit follows hardware, one cycle later
    a_r5_active_hi: assert property (@(posedge clk) disable iff (!rst_n)
        hw_active |=> sta[0]);
    a_r5_active_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_active |=> !sta[0]);
    // R6: write-one clears interrupt flag absent a hardware set
    a_r6_w1c_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sta && wdata_rep[2] && !hw_irq_set) |=> !sta[2]);
    // R7: hardware set wins
    a_r7_hw_irq: assert property (@(posedge clk) disable iff (!rst_n)
        hw_irq_set |=> sta[2]);
    a_r7_hw_err: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err_set |=> sta[1]);
    // R4: reserved status bits stay zero
    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sta[7] == 1'b0) && (sta[4:3] == 2'b00));
    // R8: pointer alignment
    a_r8_ptr_align: assert property (@(posedge clk) disable iff (!rst_n)
        ptr[1:0] == 2'b00);
endmodule

// File: rtl/bmdma_irq_mirror.sv
module bmdma_irq_mirror
    import bmdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    output logic legacy_irq,
    output logic cfg_flag
);
    irq_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.legacy = irq_in;
        s_d.cfg    = irq_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign legacy_irq = s_q.legacy;
    assign cfg_flag   = s_q.cfg;

    // R9: both outputs follow the drive level after one cycle
    a_r9_cfg_follow: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |=> cfg_flag);
    a_r9_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_in |=> !cfg_flag);
    a_r9_legacy_follow: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |=> legacy_irq);
endmodule

// File: rtl/bmdma_regbank.sv
module bmdma_regbank
    import bmdma_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [$clog2(NCH)+2:0]     acc_addr,
    input  logic [1:0]                 acc_size,
    input  logic [DATA_W-1:0]          acc_wdata,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [NCH-1:0]             hw_active,
    input  logic [NCH-1:0]             hw_err_set,
    input  logic [NCH-1:0]             hw_irq_set,
    input  logic [NCH-1:0]             chan_irq,
    output logic [NCH*BYTE_W-1:0]      cmd_out,
    output logic [NCH*DATA_W-1:0]      ptr_out,
    output logic [NCH-1:0]             legacy_irq,
    output logic [NCH-1:0]             cfg_irq_flag
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int AW   = $clog2(NCH) + 3;

    logic [CH_W-1:0]    ch_sel;
    logic [2:0]         loc;
    logic               is_byte, is_half;
    logic [DATA_W-1:0]  wdata_rep;
    logic [3:0]         be_ptr;
    logic [NCH-1:0]     wr_cmd, wr_sta;
    logic [BYTE_W-1:0]  sta_v [NCH];
    logic [BYTE_W-1:0]  cmd_v [NCH];
    logic [DATA_W-1:0]  ptr_v [NCH];

    always_comb begin
        if (NCH > 1) ch_sel = CH_W'(acc_addr[AW-1:3]);
        else         ch_sel = '0;
    end
    assign loc     = acc_addr[2:0];
    assign is_byte = (acc_size == SZ_BYTE);
    assign is_half = (acc_size == SZ_HALF);

    always_comb begin
        if (is_byte)      wdata_rep = {4{acc_wdata[7:0]}};
        else if (is_half) wdata_rep = {2{acc_wdata[15:0]}};
        else              wdata_rep = acc_wdata;
        if (is_byte)      be_ptr = 4'b0001 << loc[1:0];
        else if (is_half) be_ptr = loc[1] ? 4'b1100 : 4'b0011;
        else              be_ptr = 4'b1111;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic hit;
            assign hit = acc_valid && acc_write && (ch_sel == CH_W'(c));
            assign wr_cmd[c] = hit && !loc[2] && is_byte && (loc[1:0] == 2'd0);
            assign wr_sta[c] = hit && !loc[2] && is_byte && (loc[1:0] == 2'd2);

            bmdma_chan u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_cmd     (wr_cmd[c]),
                .wr_sta     (wr_sta[c]),
                .ptr_be     ((hit && loc[2]) ? be_ptr : 4'b0000),
                .wdata_rep  (wdata_rep),
                .hw_active  (hw_active[c]),
                .hw_err_set (hw_err_set[c]),
                .hw_irq_set (hw_irq_set[c]),
                .cmd        (cmd_v[c]),
                .sta        (sta_v[c]),
                .ptr        (ptr_v[c])
            );

            bmdma_irq_mirror u_irq (
                .clk        (clk),
                .rst_n      (rst_n),
                .irq_in     (chan_irq[c]),
                .legacy_irq (legacy_irq[c]),
                .cfg_flag   (cfg_irq_flag[c])
            );

            assign cmd_out[c*BYTE_W +: BYTE_W] = cmd_v[c];
            assign ptr_out[c*DATA_W +: DATA_W] = ptr_v[c];
        end
    endgenerate

    always_comb begin
        logic [DATA_W-1:0] sel_ptr;
        sel_ptr = ptr_v[ch_sel];
        rd_data = '0;
        if (!loc[2]) begin
            if (is_half)       rd_data = 32'h0000_FFFF;
            else if (!is_byte) rd_data = 32'hFFFF_FFFF;
            else begin
                case (loc[1:0])
                    2'd0:    rd_data = {24'h0, cmd_v[ch_sel]};
                    2'd2:    rd_data = {24'h0, sta_v[ch_sel]};
                    default: rd_data = 32'h0000_00FF;
                endcase
            end
        end else begin
            if (is_byte)      rd_data = {24'h0, sel_ptr[{loc[1:0], 3'b000} +: 8]};
            else if (is_half) rd_data = {16'h0, sel_ptr[{loc[1], 4'b0000} +: 16]};
            else              rd_data = sel_ptr;
        end
    end

    // R2: a wide write to the command/status word leaves commands alone
    a_r2_wide_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !loc[2] && !is_byte) |=> $stable(cmd_out));
    // R1: a write to channel 1 never alters channel 0 command or pointer
    a_r1_ch_isolate: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (ch_sel != '0)) |=>
            ($stable(cmd_out[BYTE_W-1:0]) && $stable(ptr_out[DATA_W-1:0])));
endmodule

// File: tb/bmdma_regbank_tb.sv
module bmdma_regbank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  hw_active = '0, hw_err_set = '0, hw_irq_set = '0, chan_irq = '0;
    logic [15:0] cmd_out;
    logic [63:0] ptr_out;
    logic [1:0]  legacy_irq, cfg_irq_flag;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bmdma_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .hw_active(hw_active), .hw_err_set(hw_err_set),
        .hw_irq_set(hw_irq_set), .chan_irq(chan_irq), .cmd_out(cmd_out),
        .ptr_out(ptr_out), .legacy_irq(legacy_irq), .cfg_irq_flag(cfg_irq_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        acc_addr = a; acc_size = sz;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, 2'b00, v); chk("R10 cmd0", v, 32'h0);
        rd(4'h2, 2'b00, v); chk("R10 sta0", v, 32'h0);
        rd(4'hC, 2'b10, v); chk("R10 ptr1", v, 32'h0);
        chk("R10 irq", {28'h0, legacy_irq, cfg_irq_flag}, 32'h0);
    endtask

    task automatic t_cmd_decode();
        logic [31:0] v;
        wr(4'h0, 2'b00, 32'h01);
        wr(4'h8, 2'b00, 32'h09);
        rd(4'h0, 2'b00, v); chk("R1 cmd0", v, 32'h01);
        rd(4'h8, 2'b00, v); chk("R1 cmd1", v, 32'h09);
        chk("R1 cmd_out", {16'h0, cmd_out}, 32'h0901);
    endtask

    task automatic t_wide();
        logic [31:0] v;
        wr(4'h0, 2'b10, 32'hFFFF_FFFF);
        wr(4'h2, 2'b01, 32'h0000_FFFF);
        rd(4'h0, 2'b00, v); chk("R2 wide write cmd", v, 32'h01);
        rd(4'h2, 2'b00, v); chk("R2 wide write sta", v, 32'h00);
        rd(4'h0, 2'b01, v); chk("R2 half read", v, 32'h0000_FFFF);
        rd(4'h8, 2'b10, v); chk("R2 word read", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_holes();
        logic [31:0] v;
        wr(4'h1, 2'b00, 32'h55);
        wr(4'h3, 2'b00, 32'h66);
        rd(4'h1, 2'b00, v); chk("R3 off1", v, 32'hFF);
        rd(4'hB, 2'b00, v); chk("R3 off3", v, 32'hFF);
        rd(4'h0, 2'b00, v); chk("R3 cmd kept", v, 32'h01);
        rd(4'h2, 2'b00, v); chk("R3 sta kept", v, 32'h00);
    endtask

    task automatic t_status();
        logic [31:0] v;
        wr(4'h2, 2'b00, 32'hFF);
        rd(4'h2, 2'b00, v); chk("R4 sta bits 6:5", v, 32'h60);
        @(negedge clk); hw_err_set = 2'b01; hw_irq_set = 2'b01;
        @(negedge clk); hw_err_set = 2'b00; hw_irq_set = 2'b00;
        rd(4'h2, 2'b00, v); chk("R7 hw set", v, 32'h66);
        rd(4'hA, 2'b00, v); chk("R1 sta1 untouched", v, 32'h00);
        wr(4'h2, 2'b00, 32'h04);
        rd(4'h2, 2'b00, v); chk("R6 clear irq only", v, 32'h02);
        wr(4'h2, 2'b00, 32'h00);
        rd(4'h2, 2'b00, v); chk("R6 write zero keeps", v, 32'h02);
        wr(4'h2, 2'b00, 32'h02);
        rd(4'h2, 2'b00, v); chk("R6 clear err", v, 32'h00);
    endtask

    task automatic t_active();
        logic [31:0] v;
        @(negedge clk); hw_active = 2'b10;
        rd(4'hA, 2'b00, v); chk("R5 active set", v, 32'h01);
        wr(4'hA, 2'b00, 32'h00);
        rd(4'hA, 2'b00, v); chk("R5 sw no effect", v, 32'h01);
        @(negedge clk); hw_active = 2'b00;
        rd(4'hA, 2'b00, v); chk("R5 active clear", v, 32'h00);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        @(negedge clk); hw_err_set = 2'b10; hw_irq_set = 2'b10;
        @(negedge clk); hw_err_set = 2'b00; hw_irq_set = 2'b00;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'hA; acc_size = 2'b00;
        acc_wdata = 32'h06; hw_irq_set = 2'b10;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; hw_irq_set = 2'b00;
        rd(4'hA, 2'b00, v); chk("R7 set beats clear", v, 32'h04);
    endtask

    task automatic t_ptr();
        logic [31:0] v;
        wr(4'h4, 2'b10, 32'h1234_5677);
        rd(4'h4, 2'b10, v); chk("R8 word", v, 32'h1234_5674);
        wr(4'h6, 2'b00, 32'hAB);
        rd(4'h4, 2'b10, v); chk("R8 byte lane2", v, 32'h12AB_5674);
        wr(4'h4, 2'b01, 32'hFFFF);
        rd(4'h4, 2'b10, v); chk("R8 half low", v, 32'h12AB_FFFC);
        rd(4'h5, 2'b00, v); chk("R8 byte read", v, 32'hFF);
        rd(4'h6, 2'b01, v); chk("R8 half read", v, 32'h12AB);
        wr(4'hC, 2'b10, 32'hDEAD_BEEF);
        rd(4'hC, 2'b10, v); chk("R8 ptr1", v, 32'hDEAD_BEEC);
        rd(4'h4, 2'b10, v); chk("R1 ptr0 kept", v, 32'h12AB_FFFC);
    endtask

    task automatic t_irq();
        @(negedge clk); chan_irq = 2'b01;
        @(negedge clk);
        chk("R9 ch0 high", {28'h0, legacy_irq, cfg_irq_flag}, 32'h5);
        chan_irq = 2'b10;
        @(negedge clk);
        chk("R9 ch1 high", {28'h0, legacy_irq, cfg_irq_flag}, 32'hA);
        chan_irq = 2'b00;
        @(negedge clk);
        chk("R9 low", {28'h0, legacy_irq, cfg_irq_flag}, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd_decode();
        t_wide();
        t_holes();
        t_status();
        t_active();
        t_priority();
        t_ptr();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule